// File: doc/BRIEF.md
# Packet Ring-Buffer DMA Writer

This block receives a byte stream of fixed-length transport packets and stores it into a circular region of host memory. It groups incoming bytes into 32-bit words, least significant byte first, and hands each word to a memory write port that uses a valid/ready handshake. Each word goes to the next ascending host address. The ring is built from blocks of packets. Its whole geometry comes from one packed size register: a packet length, a count of packets per block and a count of blocks per ring. When the head of the ring passes the last byte it returns to the programmed base address.

Software controls the engine through eight 32-bit registers. The control/status word has a write-1-to-set alias and a write-1-to-clear alias. Interrupts fire on two events. The first is the completion of each block. The second is an idle period, counted in clock ticks, that ends while a block is only partly filled. That second event lets software pick up a short tail of traffic. A small word FIFO absorbs stalls on the memory side. When the FIFO is full, an offered byte is dropped and a sticky error flag is set.

Top module: `pkt_ring_writer`

## Requirements
- R1: Registers are selected by `reg_idx`: 0 geometry, 1 timeout, 2 base address bits 31:0, 3 base address bits 63:32, 4 control set alias, 5 control clear alias, 6 head address bits 31:0, 7 head address bits 63:32. Reads return data combinationally. Indices 4 and 5 both read the status word. After reset the geometry reads 0x088000BC (packet length in bits 7:0, packets per block in bits 23:16, blocks per ring in bits 31:24, bits 15:8 read zero), and the status, timeout, base and head all read zero.
- R2: The status word has RUN at bit 0, ERROR at bit 1, interrupt enable at bit 8 and interrupt pending at bit 9. All other bits read zero. Writing index 4 sets each of these bits whose written bit is 1. Writing index 5 clears each of these bits whose written bit is 1. Written zeros leave a bit unchanged.
- R3: Accepted bytes are packed four to a word, with the first byte in bits 7:0. Words are written to ascending addresses that step by 4. The first word after a restart goes to the base address with its two low bits forced to zero.
- R4: A block holds (packet length with its two low bits cleared) × packets per block bytes. The ring holds that block size × blocks per ring bytes. The word after the last word of the ring is written to the aligned base address.
- R5: The head address (indices 6 and 7) reads as the aligned base address plus the ring offset of the next word to be issued.
- R6: When the write handshake of the last word of a block completes, the interrupt-pending bit is set.
- R7: The `irq` output is high exactly when both interrupt pending and interrupt enable are set.
- R8: A nonzero timeout T sets interrupt pending T clock edges after the last accepted byte. This happens only if RUN is set at that edge and the current block holds at least one accepted byte. Each quiet period fires at most once. A timeout of zero disables this event.
- R9: A byte offered while RUN is set and the word FIFO is full is dropped, and ERROR is set. ERROR stays set until software clears it.
- R10: While RUN is clear, offered bytes are ignored, no ERROR is raised, and no new word is issued. A word already presented on the memory port stays there until it is accepted.
- R11: Writing 1 to bit 0 of the set alias restarts the ring. The head offset returns to zero, and staged words and partial bytes are discarded.
- R12: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input byte |
| mem_valid | output | 1 | Memory write request valid |
| mem_ready | input | 1 | Memory write request accepted |
| mem_addr | output | 64 | Host byte address of the word |
| mem_data | output | 32 | Word to write |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a two-word FIFO. With that depth, a stalled memory port fills the staging path after only twelve bytes, so the drop and ERROR path is reached in a few cycles. Through the size register, the bench programs packets of eleven bytes, which the engine treats as eight, with two packets per block and three blocks per ring. This gives a 16-byte block and a 48-byte ring, so block interrupts, wrap-around, timeout flushes on a partly filled block, and stop and restart behaviour all occur within about fifty bytes of traffic. The reset geometry is checked only through readback.

// File: rtl/prw_pkg.sv
package prw_pkg;
    localparam int WORD_W    = 32;
    localparam int WORD_BYTES = WORD_W / 8;
    localparam int ADDR_W    = 64;

    typedef enum logic [2:0] {
        RI_GEOM    = 3'd0,
        RI_TMO     = 3'd1,
        RI_BASE_LO = 3'd2,
        RI_BASE_HI = 3'd3,
        RI_CTL_SET = 3'd4,
        RI_CTL_CLR = 3'd5,
        RI_HEAD_LO = 3'd6,
        RI_HEAD_HI = 3'd7
    } reg_idx_e;

    localparam int CB_RUN  = 0;
    localparam int CB_ERR  = 1;
    localparam int CB_IEN  = 8;
    localparam int CB_PEND = 9;

    typedef struct packed {
        logic        run;
        logic        err;
        logic        ien;
        logic        pend;
        logic [63:0] base;
        logic [7:0]  pkt;
        logic [7:0]  ppb;
        logic [7:0]  nblk;
        logic [31:0] tmo;
    } regs_t;
endpackage

// File: rtl/prw_regs.sv
module prw_regs
    import prw_pkg::*;
#(
    parameter int RST_PKT_BYTES = 188,
    parameter int RST_BLK_PKTS  = 128,
    parameter int RST_RING_BLKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] head_off,
    input  logic        ev_blk,
    input  logic        ev_tmo,
    input  logic        ev_drop,
    output logic        run,
    output logic        restart,
    output logic [63:0] base_al,
    output logic [31:0] blk_bytes,
    output logic [31:0] ring_bytes,
    output logic [31:0] tmo,
    output logic        irq
);
    regs_t r_d, r_q;
    logic [31:0] stat_w;
    logic [63:0] head_addr;

    always_comb begin
        r_d     = r_q;
        restart = 1'b0;
        if (reg_we) begin
            case (reg_idx_e'(reg_idx))
                RI_GEOM: begin
                    r_d.pkt  = reg_wdata[7:0];
                    r_d.ppb  = reg_wdata[23:16];
                    r_d.nblk = reg_wdata[31:24];
                end
                RI_TMO:     r_d.tmo          = reg_wdata;
                RI_BASE_LO: r_d.base[31:0]   = reg_wdata;
                RI_BASE_HI: r_d.base[63:32]  = reg_wdata;
                RI_CTL_SET: begin
                    if (reg_wdata[CB_RUN]) begin
                        r_d.run = 1'b1;
                        restart = 1'b1;
                    end
                    if (reg_wdata[CB_ERR])  r_d.err  = 1'b1;
                    if (reg_wdata[CB_IEN])  r_d.ien  = 1'b1;
                    if (reg_wdata[CB_PEND]) r_d.pend = 1'b1;
                end
                RI_CTL_CLR: begin
                    if (reg_wdata[CB_RUN])  r_d.run  = 1'b0;
                    if (reg_wdata[CB_ERR])  r_d.err  = 1'b0;
                    if (reg_wdata[CB_IEN])  r_d.ien  = 1'b0;
                    if (reg_wdata[CB_PEND]) r_d.pend = 1'b0;
                end
                default: ;
            endcase
        end
        // hardware events take priority over a software clear in the same cycle
        if (ev_blk || ev_tmo) r_d.pend = 1'b1;
        if (ev_drop)          r_d.err  = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.pkt  <= 8'(RST_PKT_BYTES);
            r_q.ppb  <= 8'(RST_BLK_PKTS);
            r_q.nblk <= 8'(RST_RING_BLKS);
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        stat_w          = '0;
        stat_w[CB_RUN]  = r_q.run;
        stat_w[CB_ERR]  = r_q.err;
        stat_w[CB_IEN]  = r_q.ien;
        stat_w[CB_PEND] = r_q.pend;
        base_al    = {r_q.base[63:2], 2'b00};
        head_addr  = base_al + {32'd0, head_off};
        blk_bytes  = 32'({r_q.pkt[7:2], 2'b00}) * 32'(r_q.ppb);
        ring_bytes = blk_bytes * 32'(r_q.nblk);
        case (reg_idx_e'(reg_idx))
            RI_GEOM:    reg_rdata = {r_q.nblk, r_q.ppb, 8'h00, r_q.pkt};
            RI_TMO:     reg_rdata = r_q.tmo;
            RI_BASE_LO: reg_rdata = r_q.base[31:0];
            RI_BASE_HI: reg_rdata = r_q.base[63:32];
            RI_HEAD_LO: reg_rdata = head_addr[31:0];
            RI_HEAD_HI: reg_rdata = head_addr[63:32];
            default:    reg_rdata = stat_w;
        endcase
    end

    assign run = r_q.run;
    assign tmo = r_q.tmo;
    assign irq = r_q.pend & r_q.ien;

    // R6: pending stays set until software clears it
    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pend && !(reg_we && reg_idx == 3'(RI_CTL_CLR) && reg_wdata[CB_PEND]) |=> r_q.pend);

    // R9: a dropped byte leaves ERROR set
    a_r9_drop_sets_err: assert property (@(posedge clk) disable iff (!rst_n)
        ev_drop |=> r_q.err);
endmodule

// File: rtl/prw_packer.sv
module prw_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    input  logic        fifo_full,
    input  logic [31:0] blk_bytes,
    input  logic [31:0] tmo,
    output logic        push,
    output logic [31:0] push_word,
    output logic        ev_drop,
    output logic        ev_tmo
);
    typedef struct packed {
        logic [23:0] acc;
        logic [1:0]  cnt;
        logic [31:0] blk_cnt;
        logic [31:0] idle;
    } pk_t;

    pk_t s_d, s_q;
    logic offer, take;

    always_comb begin
        s_d       = s_q;
        push      = 1'b0;
        ev_tmo    = 1'b0;
        offer     = in_valid && run;
        take      = offer && !fifo_full;
        ev_drop   = offer && fifo_full;
        push_word = {in_byte, s_q.acc};
        if (take) begin
            case (s_q.cnt)
                2'd0: s_d.acc[7:0]   = in_byte;
                2'd1: s_d.acc[15:8]  = in_byte;
                2'd2: s_d.acc[23:16] = in_byte;
                default: push = 1'b1;
            endcase
            s_d.cnt  = s_q.cnt + 2'd1;
            s_d.idle = '0;
            if (s_q.blk_cnt + 32'd1 >= blk_bytes) s_d.blk_cnt = '0;
            else                                  s_d.blk_cnt = s_q.blk_cnt + 32'd1;
        end else if (tmo != '0 && s_q.idle != tmo) begin
            s_d.idle = s_q.idle + 32'd1;
            if (s_q.idle + 32'd1 == tmo && s_q.blk_cnt != '0 && run) ev_tmo = 1'b1;
        end
        if (restart) begin
            s_d     = '0;
            push    = 1'b0;
            ev_tmo  = 1'b0;
            ev_drop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/prw_fifo.sv
module prw_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PTR_W-1:0]        wp;
        logic [PTR_W-1:0]        rp;
        logic [CNT_W-1:0]        cnt;
    } ff_t;

    ff_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = wdata;
            s_d.wp = (s_q.wp == PTR_W'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) s_d.rp = (s_q.rp == PTR_W'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: ;
        endcase
        if (clear) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.mem[s_q.rp];
    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CNT_W'(DEPTH));

    // R9: the packer never pushes into a full FIFO
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/prw_writer.sv
module prw_writer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run,
    input  logic        restart,
    input  logic [63:0] base_al,
    input  logic [31:0] blk_bytes,
    input  logic [31:0] ring_bytes,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_word,
    output logic        pop,
    input  logic        mem_ready,
    output logic        mem_valid,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_data,
    output logic [31:0] head_off,
    output logic        ev_blk
);
    typedef struct packed {
        logic        vld;
        logic        last;
        logic [63:0] addr;
        logic [31:0] data;
        logic [31:0] off;
        logic [31:0] boff;
    } wr_t;

    wr_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        ev_blk = s_q.vld && mem_ready && s_q.last;
        if (s_q.vld && mem_ready) s_d.vld = 1'b0;
        pop = run && !restart && !fifo_empty && (!s_q.vld || mem_ready);
        if (pop) begin
            s_d.vld  = 1'b1;
            s_d.addr = base_al + {32'd0, s_q.off};
            s_d.data = fifo_word;
            s_d.last = (s_q.boff + 32'd4 >= blk_bytes);
            s_d.boff = s_d.last ? '0 : s_q.boff + 32'd4;
            s_d.off  = (s_q.off + 32'd4 >= ring_bytes) ? '0 : s_q.off + 32'd4;
        end
        if (restart) begin
            s_d.off  = '0;
            s_d.boff = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_valid = s_q.vld;
    assign mem_addr  = s_q.addr;
    assign mem_data  = s_q.data;
    assign head_off  = s_q.off;

    // R12: a stalled request holds still
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data));
    // R10: no new request is started while stopped
    a_r10_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !mem_valid |=> !mem_valid);
    // R11: a restart returns the head to the ring start
    a_r11_restart_head: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> head_off == '0);
    // R3: every issued address is word aligned
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> mem_addr[1:0] == 2'b00);
endmodule

// File: rtl/pkt_ring_writer.sv
module pkt_ring_writer
    import prw_pkg::*;
#(
    parameter int FIFO_DEPTH    = 4,
    parameter int RST_PKT_BYTES = 188,
    parameter int RST_BLK_PKTS  = 128,
    parameter int RST_RING_BLKS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_idx,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        mem_valid,
    input  logic        mem_ready,
    output logic [63:0] mem_addr,
    output logic [31:0] mem_data,
    output logic        irq
);
    logic        run, restart;
    logic [63:0] base_al;
    logic [31:0] blk_bytes, ring_bytes, tmo, head_off;
    logic        ev_blk, ev_tmo, ev_drop;
    logic        push, pop, fifo_empty, fifo_full;
    logic [WORD_W-1:0] push_word, fifo_word;

    prw_regs #(
        .RST_PKT_BYTES (RST_PKT_BYTES),
        .RST_BLK_PKTS  (RST_BLK_PKTS),
        .RST_RING_BLKS (RST_RING_BLKS)
    ) i_regs (
        .clk, .rst_n, .reg_we, .reg_idx, .reg_wdata, .reg_rdata,
        .head_off, .ev_blk, .ev_tmo, .ev_drop,
        .run, .restart, .base_al, .blk_bytes, .ring_bytes, .tmo, .irq
    );

    prw_packer i_packer (
        .clk, .rst_n, .run, .restart, .in_valid, .in_byte,
        .fifo_full, .blk_bytes, .tmo,
        .push, .push_word, .ev_drop, .ev_tmo
    );

    prw_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) i_fifo (
        .clk, .rst_n, .clear(restart), .push, .wdata(push_word),
        .pop, .rdata(fifo_word), .empty(fifo_empty), .full(fifo_full)
    );

    prw_writer i_writer (
        .clk, .rst_n, .run, .restart, .base_al, .blk_bytes, .ring_bytes,
        .fifo_empty, .fifo_word, .pop, .mem_ready,
        .mem_valid, .mem_addr, .mem_data, .head_off, .ev_blk
    );
endmodule

// File: tb/test_pkt_ring_writer.sv
`timescale 1ns/1ps
module test_pkt_ring_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_idx = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        mem_valid;
    logic        mem_ready = 1'b0;
    logic [63:0] mem_addr;
    logic [31:0] mem_data;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [63:0] BASE_RAW = 64'h0000_0001_0000_2003;
    localparam logic [63:0] BASE     = 64'h0000_0001_0000_2000;
    localparam logic [31:0] GEOM     = 32'h0302_000B; // 11-byte packets (used as 8), 2 per block, 3 blocks

    always #2 clk = ~clk;

    pkt_ring_writer #(.FIFO_DEPTH(2)) i_pkt_ring_writer (
        .clk, .rst_n, .reg_we, .reg_idx, .reg_wdata, .reg_rdata,
        .in_valid, .in_byte, .mem_valid, .mem_ready, .mem_addr, .mem_data, .irq
    );

    logic [63:0] wr_addr [0:255];
    logic [31:0] wr_data [0:255];
    int wr_n = 0;
    always @(posedge clk) begin
        if (rst_n && mem_valid && mem_ready) begin
            if (wr_n < 256) begin
                wr_addr[wr_n] <= mem_addr;
                wr_data[wr_n] <= mem_data;
            end
            wr_n <= wr_n + 1;
        end
    end

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] idx, logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_idx = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_idx = idx;
        #0.5;
        val = reg_rdata;
    endtask

    task automatic send(logic [7:0] first, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_byte  = first + 8'(i);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic head(output logic [63:0] h);
        logic [31:0] lo, hi;
        rd(3'd6, lo);
        rd(3'd7, hi);
        h = {hi, lo};
    endtask

    task automatic setup(logic ready);
        wr(3'd5, 32'h0000_0303);
        wr(3'd0, GEOM);
        wr(3'd1, 32'd0);
        wr(3'd2, BASE_RAW[31:0]);
        wr(3'd3, BASE_RAW[63:32]);
        mem_ready = ready;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 reset geometry", v, 32'h0880_00BC);
        rd(3'd4, v); chk("R1 reset status", v, 0);
        rd(3'd1, v); chk("R1 reset timeout", v, 0);
        rd(3'd6, v); chk("R1 reset head lo", v, 0);
        rd(3'd3, v); chk("R1 reset base hi", v, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset mem_valid", mem_valid, 0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(3'd4, 32'hFFFF_FFFE);
        rd(3'd4, v); chk("R2 set alias, unused bits zero", v, 32'h0000_0302);
        chk("R7 irq with enable and pending", irq, 1);
        wr(3'd5, 32'h0000_0200);
        rd(3'd5, v); chk("R2 clear alias pending", v, 32'h0000_0102);
        chk("R7 irq low without pending", irq, 0);
        wr(3'd5, 32'h0);
        rd(3'd4, v); chk("R2 zero write no effect", v, 32'h0000_0102);
        wr(3'd4, 32'h0);
        rd(3'd4, v); chk("R2 zero set no effect", v, 32'h0000_0102);
        wr(3'd5, 32'h0000_0102);
        rd(3'd4, v); chk("R2 clear all", v, 0);
    endtask

    task automatic t_pack();
        logic [63:0] h;
        int s;
        setup(1'b1);
        wr(3'd4, 32'h1);
        head(h); chk("R5 head after start", h, BASE);
        s = wr_n;
        send(8'h10, 8);
        idle(10);
        chk("R3 word count", 64'(wr_n - s), 2);
        chk("R3 addr0 aligned base", wr_addr[s], BASE);
        chk("R3 data0 little endian", 64'(wr_data[s]), 64'h1312_1110);
        chk("R3 addr1", wr_addr[s+1], BASE + 4);
        chk("R3 data1", 64'(wr_data[s+1]), 64'h1716_1514);
        head(h); chk("R5 head after two words", h, BASE + 8);
    endtask

    task automatic t_block();
        logic [31:0] v;
        setup(1'b1);
        wr(3'd4, 32'h0000_0101);
        send(8'h20, 12);
        idle(10);
        rd(3'd4, v); chk("R6 no pending before block end", 64'(v[9]), 0);
        chk("R7 irq low before block end", irq, 0);
        send(8'h2C, 4);
        idle(10);
        rd(3'd4, v); chk("R4 R6 pending at 16-byte block", 64'(v[9]), 1);
        chk("R7 irq on block", irq, 1);
        wr(3'd5, 32'h0000_0200);
        chk("R7 irq cleared", irq, 0);
    endtask

    task automatic t_wrap();
        logic [63:0] h;
        int s;
        setup(1'b1);
        wr(3'd4, 32'h1);
        s = wr_n;
        send(8'h00, 52);
        idle(10);
        chk("R4 word count", 64'(wr_n - s), 13);
        chk("R4 last word of ring", wr_addr[s+11], BASE + 44);
        chk("R4 wrap to base", wr_addr[s+12], BASE);
        chk("R4 data after wrap", 64'(wr_data[s+12]), 64'h3332_3130);
        head(h); chk("R5 head after wrap", h, BASE + 4);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        setup(1'b1);
        wr(3'd1, 32'd20);
        wr(3'd4, 32'h1);
        send(8'h50, 3);
        idle(12);
        rd(3'd4, v); chk("R8 no timeout early", 64'(v[9]), 0);
        idle(12);
        rd(3'd4, v); chk("R8 timeout on partial block", 64'(v[9]), 1);
        wr(3'd5, 32'h0000_0200);
        idle(40);
        rd(3'd4, v); chk("R8 fires once per quiet period", 64'(v[9]), 0);
        send(8'h53, 13);
        idle(10);
        wr(3'd5, 32'h0000_0200);
        idle(40);
        rd(3'd4, v); chk("R8 no timeout on empty block", 64'(v[9]), 0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        logic [63:0] a0;
        int s;
        setup(1'b0);
        wr(3'd4, 32'h1);
        s = wr_n;
        send(8'h40, 12);
        idle(3);
        rd(3'd4, v); chk("R9 no error while room", 64'(v[1]), 0);
        chk("R12 valid while stalled", mem_valid, 1);
        a0 = mem_addr;
        chk("R12 addr while stalled", a0, BASE);
        idle(5);
        chk("R12 addr stable", mem_addr, a0);
        chk("R12 data stable", 64'(mem_data), 64'h4342_4140);
        send(8'h4C, 1);
        rd(3'd4, v); chk("R9 error on drop", 64'(v[1]), 1);
        mem_ready = 1'b1;
        idle(10);
        chk("R9 words kept", 64'(wr_n - s), 3);
        chk("R9 last kept word", 64'(wr_data[s+2]), 64'h4B4A_4948);
        idle(5);
        rd(3'd4, v); chk("R9 error sticky", 64'(v[1]), 1);
        wr(3'd5, 32'h2);
        rd(3'd4, v); chk("R2 error cleared", 64'(v[1]), 0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        logic [63:0] h;
        int s;
        setup(1'b0);
        wr(3'd4, 32'h1);
        s = wr_n;
        send(8'h60, 10);
        idle(3);
        wr(3'd5, 32'h1);
        send(8'h70, 4);
        mem_ready = 1'b1;
        idle(15);
        chk("R10 only in-flight word written", 64'(wr_n - s), 1);
        chk("R10 in-flight data", 64'(wr_data[s]), 64'h6362_6160);
        rd(3'd4, v); chk("R10 no error while stopped", 64'(v[1]), 0);
        head(h); chk("R10 head frozen", h, BASE + 4);
        wr(3'd4, 32'h1);
        head(h); chk("R11 head reloaded", h, BASE);
        send(8'h80, 4);
        idle(10);
        chk("R11 one new word", 64'(wr_n - s), 2);
        chk("R11 restart addr", wr_addr[s+1], BASE);
        chk("R11 staged data discarded", 64'(wr_data[s+1]), 64'h8382_8180);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_alias();
        t_pack();
        t_block();
        t_wrap();
        t_timeout();
        t_drop();
        t_stop();
        idle(5);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule